// File: doc/BRIEF.md
# Keyed-Service System Watchdog

This block is a system watchdog timer on a simple synchronous register bus. Software programs one control word that carries a 16-bit reload count, an enable, an optional divide-by-65536 prescale, a debug freeze permission and a choice of expiry action. Once the watchdog runs, a down-counter falls toward zero. Software has to service it in time by writing a fixed two-word key to the service register, and that key reloads the counter. If the counter runs out, the block either raises a one-cycle reset request toward the system reset logic or raises a sticky interrupt.

The control word can be written once after power-on reset and never again. A running watchdog therefore cannot be stopped, and a watchdog left disabled cannot be started later. Software reads the control word back to learn whether the enable took effect. It can watch the live count, and it can read a sticky flag telling whether the watchdog caused the last reset. The flag is cleared by writing 1.

Registers sit at word addresses on `bus_addr`: 0 control, 1 live count (read-only), 2 service (writes only, reads 0), 3 reset status. Writes take effect at the rising clock edge on which `bus_we` is high. `bus_rdata` is combinational from `bus_addr`.

Top module: `wdog_keyed`

## Requirements
- R1: After power-on reset (`rst_n` low) the control, count and status registers read 0, `rst_req` and `irq` are low, and the counter holds at 0.
- R2: The control register at address 0 reads back the written value in bits 31:16 (reload count), bit 3 (freeze permission), bit 2 (enable), bit 1 (expiry action, 1 = reset request, 0 = interrupt) and bit 0 (prescale enable). All other bits read 0.
- R3: Only the first write to the control register after power-on reset is accepted. Later writes leave its read-back value and the counter's behaviour unchanged, both when the first write enabled the watchdog and when it did not.
- R4: A first control write with the enable bit set loads the counter from bits 31:16 at that edge. Without prescale, the counter then drops by one on every clock, and address 1 shows its value.
- R5: With the prescale bit set, the counter drops by one every 65536 clocks, with the first step 65536 clocks after the enabling write.
- R6: A write of 0x556C to address 2 (bits 15:0) followed by a write of 0xAA39 reloads the counter from the reload count at the edge of the second write. Other bus activity between the two writes does not break the pair.
- R7: Any write to address 2 that is not the expected next key word cancels a pending sequence. A write of 0x556C always leaves the sequence waiting for 0xAA39. A lone 0xAA39, or a second 0xAA39 right after a completed pair, does not reload the counter.
- R8: With reset action selected, when the counter is at 0 and takes one more step, `rst_req` goes high for one clock and the counter reloads from the reload count. Reload count N therefore gives a pulse N+1 steps after loading, repeating every N+1 steps.
- R9: With interrupt action selected, expiry sets `irq`, which stays high until the next valid key pair. `rst_req` stays low in this mode.
- R10: Bit 0 of address 3 is set when a reset request is raised. Writing 1 to it clears it, writing 0 has no effect, and further reset requests do not clear it.
- R11: While the freeze permission bit is set and `debug_freeze` is high, the counter and the prescaler hold their values. `debug_freeze` has no effect when the permission bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 2 | Word address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| debug_freeze | input | 1 | Debug halt request; stops counting when permitted |
| rst_req | output | 1 | One-clock reset request on expiry in reset mode |
| irq | output | 1 | Sticky interrupt on expiry in interrupt mode |

## Verification
A corrupted counter or prescaler shows up at address 1 within one clock, and then at `rst_req`/`irq` when the expiry cycle lands one step off. The bench compares the count at exact cycle offsets after loading, after each service attempt and across the 65536-clock prescale boundary. A wrong key-sequence state shows as a reload that happens or fails to happen, which the count reveals two to six clocks after the key writes. This includes a sequence left waiting across idle time. A lock flag that never sets or sets too early shows on the very next control read-back, and a lost sticky flag shows on the status or interrupt pins after the expiry cycle.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
   typedef enum logic [1:0] {
      RA_CTRL    = 2'd0,
      RA_COUNT   = 2'd1,
      RA_SERVICE = 2'd2,
      RA_STATUS  = 2'd3
   } reg_addr_e;

   // control word bit positions (low end)
   localparam int CB_PRE = 0;
   localparam int CB_SEL = 1;
   localparam int CB_EN  = 2;
   localparam int CB_FRZ = 3;
   localparam int CTRL_LOW_BITS = 4;
endpackage

// File: rtl/wdog_prescale.sv
`timescale 1ns/1ps
module wdog_prescale #(
   parameter int LOG2 = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic tick
);
   generate
      if (LOG2 == 0) begin : g_none
         assign tick = run;
      end else begin : g_div
         logic [LOG2-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pre_q <= '0;
            else if (clear)  pre_q <= '0;
            else if (run)    pre_q <= pre_q + 1'b1;
         end
         assign tick = run && (&pre_q);
      end
   endgenerate
endmodule

// File: rtl/wdog_keyseq.sv
`timescale 1ns/1ps
module wdog_keyseq #(
   parameter int              KEY_W = 16,
   parameter logic [KEY_W-1:0] KEY_A = 16'h556C,
   parameter logic [KEY_W-1:0] KEY_B = 16'hAA39
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [KEY_W-1:0] word,
   output logic             match
);
   logic armed_q;

   assign match = wr && armed_q && (word == KEY_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  armed_q <= 1'b0;
      else if (wr) armed_q <= (word == KEY_A);
   end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt    = cnt_q;
   assign expire = step && !load && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load)    cnt_q <= reload_val;
      else if (expire)  cnt_q <= reload_val;
      else if (step)    cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed
   import wdog_pkg::*;
#(
   parameter int               DATA_W   = 32,
   parameter int               CNT_W    = 16,
   parameter int               PRE_LOG2 = 16,
   parameter int               KEY_W    = 16,
   parameter logic [KEY_W-1:0] KEY_A    = 16'h556C,
   parameter logic [KEY_W-1:0] KEY_B    = 16'hAA39
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              debug_freeze,
   output logic              rst_req,
   output logic              irq
);
   localparam int FIELD_LO = DATA_W - CNT_W;
   localparam logic [DATA_W-1:0] CTRL_MASK =
      {{CNT_W{1'b1}}, {(DATA_W-CNT_W-CTRL_LOW_BITS){1'b0}}, {CTRL_LOW_BITS{1'b1}}};

   generate
      if (CNT_W < 1 || CNT_W + CTRL_LOW_BITS > DATA_W) begin : g_bad_cnt
         $error("wdog_keyed: CNT_W does not fit the control word");
      end
      if (KEY_W > DATA_W) begin : g_bad_key
         $error("wdog_keyed: KEY_W wider than the data bus");
      end
      if (KEY_A == KEY_B) begin : g_same_key
         $error("wdog_keyed: key words must differ");
      end
      if (PRE_LOG2 < 0 || PRE_LOG2 > 30) begin : g_bad_pre
         $error("wdog_keyed: PRE_LOG2 out of range");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q;
   logic              locked_q;
   logic              status_q;
   logic              irq_q;
   logic              rst_req_q;

   reg_addr_e   addr;
   logic        ctrl_wr, enable_set, svc_wr, svc_ok;
   logic        run, pre_tick, step, load, expire;
   logic [CNT_W-1:0] reload_val, cnt_q;

   assign addr       = reg_addr_e'(bus_addr);
   assign ctrl_wr    = bus_we && (addr == RA_CTRL) && !locked_q;
   assign enable_set = ctrl_wr && bus_wdata[CB_EN];
   assign svc_wr     = bus_we && (addr == RA_SERVICE);
   assign run        = ctrl_q[CB_EN] && !(ctrl_q[CB_FRZ] && debug_freeze);
   assign load       = enable_set || svc_ok;
   assign reload_val = enable_set ? bus_wdata[DATA_W-1 -: CNT_W]
                                  : ctrl_q[DATA_W-1 -: CNT_W];
   assign step       = ctrl_q[CB_PRE] ? pre_tick : run;

   wdog_prescale #(.LOG2(PRE_LOG2)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load),
      .run   (run),
      .tick  (pre_tick)
   );

   wdog_keyseq #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (svc_wr),
      .word  (bus_wdata[KEY_W-1:0]),
      .match (svc_ok)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .reload_val (reload_val),
      .step       (step),
      .cnt        (cnt_q),
      .expire     (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         locked_q <= 1'b0;
      end else if (ctrl_wr) begin
         ctrl_q   <= bus_wdata & CTRL_MASK;
         locked_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req_q <= 1'b0;
         irq_q     <= 1'b0;
         status_q  <= 1'b0;
      end else begin
         rst_req_q <= expire && ctrl_q[CB_SEL];
         if (svc_ok)                          irq_q <= 1'b0;
         else if (expire && !ctrl_q[CB_SEL])  irq_q <= 1'b1;
         if (expire && ctrl_q[CB_SEL])
            status_q <= 1'b1;
         else if (bus_we && addr == RA_STATUS && bus_wdata[0])
            status_q <= 1'b0;
      end
   end

   always_comb begin
      case (addr)
         RA_CTRL:   bus_rdata = ctrl_q;
         RA_COUNT:  bus_rdata = {{FIELD_LO{1'b0}}, cnt_q};
         RA_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, status_q};
         default:   bus_rdata = '0;
      endcase
   end

   assign rst_req = rst_req_q;
   assign irq     = irq_q;
endmodule

// File: rtl/wdog_keyed_chk.sv
`timescale 1ns/1ps
module wdog_keyed_chk
   import wdog_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_req,
   input logic              irq,
   input logic              debug_freeze,
   input logic [DATA_W-1:0] ctrl,
   input logic              locked,
   input logic [CNT_W-1:0]  cnt,
   input logic              svc_ok,
   input logic              status
);
   logic frozen;
   assign frozen = ctrl[CB_FRZ] && debug_freeze;

   // R3: a locked control word never changes
   a_r3_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(ctrl));

   // R4: unscaled counting drops by exactly one per clock
   a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_EN] && !ctrl[CB_PRE] && !frozen && !svc_ok && cnt != '0)
      |=> cnt == CNT_W'($past(cnt) - 1'b1));

   // R8: the reset request is a single-clock pulse for a nonzero reload
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && ctrl[DATA_W-1 -: CNT_W] != '0) |=> !rst_req);

   // R9: interrupt mode never requests a reset
   a_r9_no_reset_in_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[CB_SEL] |-> !rst_req);

   // R9: interrupt is held until a valid key pair
   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !svc_ok) |=> irq);

   // R10: a reset request always comes with the status flag
   a_r10_status_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> status);

   // R11: permitted freeze holds the count
   a_r11_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_EN] && frozen && !svc_ok) |=> $stable(cnt));
endmodule

bind wdog_keyed wdog_keyed_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rst_req      (rst_req),
   .irq          (irq),
   .debug_freeze (debug_freeze),
   .ctrl         (ctrl_q),
   .locked       (locked_q),
   .cnt          (cnt_q),
   .svc_ok       (svc_ok),
   .status       (status_q)
);

// File: tb/wdog_keyed_test.sv
`timescale 1ns/1ps
module wdog_keyed_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        debug_freeze = 1'b0;
   logic        rst_req, irq;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdog_keyed uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .debug_freeze(debug_freeze), .rst_req(rst_req), .irq(irq)
   );

   localparam logic [1:0]  A_CTRL = 2'd0, A_CNT = 2'd1, A_SVC = 2'd2, A_STAT = 2'd3;
   localparam logic [15:0] T_SVC = 16'h4000;

   // service vectors: {w0, w1, w2, reload index (3 = none)}
   localparam logic [49:0] VEC [10] = '{
      {16'h556C, 16'hAA39, 16'h0000, 2'd1},
      {16'h0000, 16'h556C, 16'hAA39, 2'd2},
      {16'h556C, 16'h0000, 16'hAA39, 2'd3},
      {16'h556C, 16'h556C, 16'hAA39, 2'd2},
      {16'hAA39, 16'h556C, 16'h1234, 2'd3},
      {16'hAA39, 16'hAA39, 16'hAA39, 2'd3},
      {16'h556C, 16'hAA39, 16'hAA39, 2'd1},
      {16'h556C, 16'hAA38, 16'hAA39, 2'd3},
      {16'h1234, 16'h1234, 16'h556C, 2'd3},
      {16'hAA39, 16'h0000, 16'h0000, 2'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic por();
      @(negedge clk);
      rst_n = 1'b0; bus_we = 1'b0; debug_freeze = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog (all requirements) act=timeout exp=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, c;
      int n;

      // ---- R1: reset state
      por();
      rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
      rd(A_CNT, v);  chk("R1 count", v, 32'h0);
      rd(A_STAT, v); chk("R1 status", v, 32'h0);
      chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      repeat (5) @(negedge clk);
      rd(A_CNT, v);  chk("R1 count holds", v, 32'h0);

      // ---- R2/R3: first write disabled, reserved bits masked, enable refused later
      wr(A_CTRL, 32'h0010_00F0);
      rd(A_CTRL, v); chk("R2 readback mask", v, 32'h0010_0000);
      wr(A_CTRL, 32'h0010_0004);
      rd(A_CTRL, v); chk("R3 late enable ignored", v, 32'h0010_0000);
      repeat (40) @(negedge clk);
      rd(A_CNT, v);  chk("R3 count still idle", v, 32'h0);
      chk("R3 no irq", {31'b0, irq}, 32'h0);

      // ---- R4/R8/R10/R3/R11: reset mode, T=5, freeze permitted
      por();
      wr(A_CTRL, 32'h0005_000E);
      rd(A_CTRL, v); chk("R2 readback", v, 32'h0005_000E);
      rd(A_CNT, v);  chk("R4 load", v, 32'd5);
      for (int i = 1; i <= 5; i++) begin
         @(negedge clk);
         rd(A_CNT, v); chk("R4 decrement", v, 32'(5 - i));
         chk("R8 no early pulse", {31'b0, rst_req}, 32'h0);
      end
      @(negedge clk);
      chk("R8 pulse", {31'b0, rst_req}, 32'h1);
      rd(A_CNT, v);  chk("R8 reload", v, 32'd5);
      rd(A_STAT, v); chk("R10 status set", v, 32'h1);
      @(negedge clk);
      chk("R8 pulse width", {31'b0, rst_req}, 32'h0);
      wr(A_CTRL, 32'h0005_0000);
      rd(A_CTRL, v); chk("R3 disable ignored", v, 32'h0005_000E);
      n = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (rst_req) n++;
      end
      chk("R3 still running", 32'(n > 0), 32'h1);
      rd(A_STAT, v); chk("R10 status survives pulses", v, 32'h1);
      debug_freeze = 1'b1;
      rd(A_CNT, c);
      repeat (10) @(negedge clk);
      rd(A_CNT, v);  chk("R11 frozen count", v, c);
      chk("R11 no pulse frozen", {31'b0, rst_req}, 32'h0);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R10 write 0 no effect", v, 32'h1);
      wr(A_STAT, 32'h1);
      rd(A_STAT, v); chk("R10 write 1 clears", v, 32'h0);
      debug_freeze = 1'b0;
      repeat (2) @(negedge clk);
      rd(A_CNT, v);  chk("R11 resumes", 32'(v != c), 32'h1);

      // ---- R9: interrupt mode, T=3
      por();
      wr(A_CTRL, 32'h0003_0004);
      repeat (3) @(negedge clk);
      chk("R9 irq not yet", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R9 irq set", {31'b0, irq}, 32'h1);
      chk("R9 no rst_req", {31'b0, rst_req}, 32'h0);
      repeat (20) @(negedge clk);
      chk("R9 irq sticky", {31'b0, irq}, 32'h1);
      rd(A_STAT, v); chk("R10 no status in irq mode", v, 32'h0);
      wr(A_SVC, 32'h0000_556C);
      chk("R9 irq held after first key", {31'b0, irq}, 32'h1);
      wr(A_SVC, 32'h0000_AA39);
      chk("R9 irq cleared by service", {31'b0, irq}, 32'h0);
      rd(A_CNT, v);  chk("R6 reload on pair", v, 32'd3);
      debug_freeze = 1'b1;
      rd(A_CNT, c);
      @(negedge clk);
      rd(A_CNT, v);  chk("R11 freeze needs permission", 32'(v != c), 32'h1);
      debug_freeze = 1'b0;

      // ---- R6/R7: service vector table
      por();
      wr(A_CTRL, {T_SVC, 16'h0004});
      repeat (10) @(negedge clk);
      foreach (VEC[k]) begin
         logic [1:0]  idx;
         logic [31:0] expv;
         idx = VEC[k][1:0];
         repeat (5) @(negedge clk);
         rd(A_CNT, c);
         wr(A_SVC, {16'h0, VEC[k][49:34]});
         wr(A_SVC, {16'h0, VEC[k][33:18]});
         wr(A_SVC, {16'h0, VEC[k][17:2]});
         rd(A_CNT, v);
         if (idx == 2'd3) expv = c - 32'd6;
         else             expv = 32'(T_SVC) - (32'd4 - 32'd2 * 32'(idx));
         chk(idx == 2'd3 ? "R7 no reload" : "R6 reload", v, expv);
      end

      // ---- R5: prescale, T=1
      por();
      wr(A_CTRL, 32'h0001_0005);
      rd(A_CNT, v);  chk("R5 load", v, 32'd1);
      repeat (65535) @(negedge clk);
      rd(A_CNT, v);  chk("R5 before step", v, 32'd1);
      @(negedge clk);
      rd(A_CNT, v);  chk("R5 step at 65536", v, 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule